// File: doc/BRIEF.md
# Regulator Fault Supervisor

This block is the digital fault supervisor of a multiphase buck regulator controller. Analog comparators elsewhere raise level flags for overcurrent, a fast overcurrent at 2.5 times the limit, phase current imbalance, undervoltage (300 mV below target), overvoltage (200 mV above target), severe overvoltage (above 1.7 V), and a release flag that marks the output below 0.85 V. The supervisor checks that each flag persists for its own qualification time, counted in reference-clock cycles. It then latches the fault and tells the power stage how to respond.

Ordinary faults (overcurrent, fast overcurrent, imbalance, undervoltage, overvoltage) pull power-good low and command every power switch off. These latches live in the enable domain: taking the enable input low clears them, and a new soft-start follows. Severe overvoltage runs a crowbar instead. The low-side switches turn on until the release flag rises, and then all switches turn off. The cycle repeats whenever the output climbs past 1.7 V again. This latch lives in the power-on-reset domain only. A 3-bit code reports the first fault that latched.

Top module: `fault_supervisor`

## Requirements
- R1: While `por_n` is low, and in the first cycle after it rises, `pg_kill`, `all_off` and `lowside_on` are 0 and `fault_code` is 0 (none).
- R2: An overcurrent flag held high for OC_CYC consecutive rising edges with enable high latches at the OC_CYC-th edge, and not before. The result is `pg_kill`=1, `all_off`=1 and `fault_code`=4.
- R3: If the overcurrent flag drops for even one edge before it qualifies, its count restarts from zero, and it then needs a full OC_CYC further edges.
- R4: A fast-overcurrent flag high at a single edge with enable high latches at that edge. The result is `pg_kill`=1, `all_off`=1 and `fault_code`=5.
- R5: Imbalance, undervoltage and overvoltage flags each latch after SLOW_CYC consecutive high edges, with the same action as R2. Their codes are 3, 2 and 1.
- R6: Taking enable low clears the ordinary fault latches, their counters and their code within one edge. While enable is low, the ordinary flags are ignored.
- R7: A severe-overvoltage flag high at an edge latches at once. The result is `pg_kill`=1, `lowside_on`=1, `all_off`=0 and, if no fault was recorded earlier, `fault_code`=6.
- R8: The low-side command holds until an edge where the release flag is high and the severe flag is low. From then on `all_off`=1 and `lowside_on`=0. A new severe flag turns the low side on again.
- R9: The severe-overvoltage latch and its code 6 ignore enable and clear only when `por_n` goes low. When enable clears a recorded ordinary code while this latch is set, the code becomes 6.
- R10: The severe detector stays active after an ordinary fault has latched, and its low-side command then overrides `all_off`.
- R11: `fault_code` keeps the first fault recorded. When several qualify at the same edge, it takes the highest in the order severe OV (6) > fast OC (5) > OC (4) > imbalance (3) > UV (2) > OV (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all qualification counts |
| por_n | input | 1 | Power-on-reset good, active low reset of every register |
| en | input | 1 | Regulator enable; low clears the ordinary fault domain |
| oc_flag | input | 1 | Overcurrent comparator flag |
| foc_flag | input | 1 | Fast overcurrent comparator flag |
| imb_flag | input | 1 | Phase current imbalance flag |
| uv_flag | input | 1 | Undervoltage flag |
| ov_flag | input | 1 | Overvoltage flag |
| sov_flag | input | 1 | Severe overvoltage flag (output above 1.7 V) |
| rel_flag | input | 1 | Release flag (output below 0.85 V) |
| pg_kill | output | 1 | Forces power-good low |
| all_off | output | 1 | Commands all power switches off (tri-state) |
| lowside_on | output | 1 | Commands the low-side switches on (crowbar) |
| fault_code | output | 3 | First latched fault, 0 when none |

## Verification
The hardest condition to reach is the overlap of the two reset domains. An ordinary fault must already hold the code when a severe overvoltage arrives, and then enable must drop while the crowbar is still active. Only in that state can the code move from an ordinary value to 6 while the low side stays on. The stimulus first latches a fast overcurrent and raises the severe flag on the next cycle. It then drops enable before asserting release, and finally pulls `por_n` low to show that only power-on-reset clears the state. The persistence paths are driven to exactly one edge short of their limit and then one edge further, and one run breaks the overcurrent flag partway through to show the count restarting.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
   localparam int CODE_W = 3;
   localparam int NFLT   = 6;

   // bit index in the qualified vector; code value = index + 1
   localparam int IX_OV  = 0;
   localparam int IX_UV  = 1;
   localparam int IX_IMB = 2;
   localparam int IX_OC  = 3;
   localparam int IX_FOC = 4;
   localparam int IX_SOV = 5;

   localparam logic [CODE_W-1:0] CODE_NONE = 3'd0;
   localparam logic [CODE_W-1:0] CODE_SOV  = 3'd6;
endpackage

// File: rtl/fsup_qual.sv
// Persistence qualifier: a flag must hold for CYC consecutive edges.
module fsup_qual #(
   parameter int CYC = 4
) (
   input  logic clk,
   input  logic por_n,
   input  logic clr,
   input  logic flag,
   output logic hit
);
   if (CYC < 1) begin : g_bad_cyc
      $error("fsup_qual: CYC must be at least 1");
   end

   if (CYC == 1) begin : g_immediate
      assign hit = flag && !clr;
   end else begin : g_counted
      localparam int CW = $clog2(CYC + 1);
      localparam logic [CW-1:0] LAST = CW'(CYC - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)             cnt <= '0;
         else if (clr || !flag)  cnt <= '0;
         else if (cnt != LAST)   cnt <= cnt + 1'b1;
      end

      assign hit = flag && !clr && (cnt == LAST);
   end
endmodule

// File: rtl/fsup_crowbar.sv
// Severe-overvoltage latch and hysteretic low-side loop (POR domain only).
module fsup_crowbar (
   input  logic clk,
   input  logic por_n,
   input  logic sov_flag,
   input  logic rel_flag,
   output logic sov_lat,
   output logic crow
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         sov_lat <= 1'b0;
         crow    <= 1'b0;
      end else begin
         if (sov_flag) sov_lat <= 1'b1;
         if (sov_flag)      crow <= 1'b1;
         else if (rel_flag) crow <= 1'b0;
      end
   end
endmodule

// File: rtl/fsup_code.sv
// First-fault recorder with fixed priority among same-edge arrivals.
module fsup_code
   import fsup_pkg::*;
(
   input  logic              clk,
   input  logic              por_n,
   input  logic              en,
   input  logic [NFLT-1:0]   qual,
   input  logic              sov_lat,
   output logic [CODE_W-1:0] code
);
   logic [CODE_W-1:0] enc;

   always_comb begin
      enc = CODE_NONE;
      for (int i = 0; i < NFLT; i++) begin
         if (qual[i]) enc = CODE_W'(i + 1);
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         code <= CODE_NONE;
      else if (code == CODE_NONE)
         code <= enc;
      else if (!en && code != CODE_SOV)
         code <= (sov_lat || qual[IX_SOV]) ? CODE_SOV : CODE_NONE;
   end
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
   import fsup_pkg::*;
#(
   parameter int OC_CYC   = 120,
   parameter int SLOW_CYC = 1000
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              en,
   input  logic              oc_flag,
   input  logic              foc_flag,
   input  logic              imb_flag,
   input  logic              uv_flag,
   input  logic              ov_flag,
   input  logic              sov_flag,
   input  logic              rel_flag,
   output logic              pg_kill,
   output logic              all_off,
   output logic              lowside_on,
   output logic [CODE_W-1:0] fault_code
);
   if (OC_CYC < 1 || SLOW_CYC < 1) begin : g_bad_par
      $error("fault_supervisor: qualification times must be at least 1");
   end

   localparam int NORD = NFLT - 1;

   logic [NFLT-1:0] qual;
   logic [NORD-1:0] raw;
   logic            ord_lat, sov_lat, crow;
   logic            clr;

   assign clr = !en;
   assign raw[IX_OV]  = ov_flag;
   assign raw[IX_UV]  = uv_flag;
   assign raw[IX_IMB] = imb_flag;
   assign raw[IX_OC]  = oc_flag;
   assign raw[IX_FOC] = foc_flag;

   for (genvar g = 0; g < NORD; g++) begin : g_qual
      localparam int LEN = (g == IX_FOC) ? 1 :
                           (g == IX_OC)  ? OC_CYC : SLOW_CYC;
      fsup_qual #(.CYC(LEN)) u_q (
         .clk  (clk),
         .por_n(por_n),
         .clr  (clr),
         .flag (raw[g]),
         .hit  (qual[g])
      );
   end
   assign qual[IX_SOV] = sov_flag;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)              ord_lat <= 1'b0;
      else if (!en)            ord_lat <= 1'b0;
      else if (|qual[NORD-1:0]) ord_lat <= 1'b1;
   end

   fsup_crowbar u_crow (
      .clk     (clk),
      .por_n   (por_n),
      .sov_flag(sov_flag),
      .rel_flag(rel_flag),
      .sov_lat (sov_lat),
      .crow    (crow)
   );

   fsup_code u_code (
      .clk    (clk),
      .por_n  (por_n),
      .en     (en),
      .qual   (qual),
      .sov_lat(sov_lat),
      .code   (fault_code)
   );

   assign pg_kill    = ord_lat || sov_lat;
   assign lowside_on = crow;
   assign all_off    = (ord_lat || sov_lat) && !crow;
endmodule

// File: rtl/fsup_checker.sv
module fsup_checker (
   input logic       clk,
   input logic       por_n,
   input logic       en,
   input logic       foc_flag,
   input logic       sov_flag,
   input logic       rel_flag,
   input logic       pg_kill,
   input logic       all_off,
   input logic       lowside_on,
   input logic [2:0] fault_code
);
   p_foc_immediate_r4: assert property (@(posedge clk) disable iff (!por_n)
      (en && foc_flag) |=> (pg_kill && (all_off || lowside_on)));

   p_sov_crowbar_r7: assert property (@(posedge clk) disable iff (!por_n)
      sov_flag |=> (lowside_on && pg_kill));

   p_release_r8: assert property (@(posedge clk) disable iff (!por_n)
      (lowside_on && rel_flag && !sov_flag) |=> (!lowside_on && all_off));

   p_sov_sticky_r9: assert property (@(posedge clk) disable iff (!por_n)
      (fault_code == 3'd6) |=> (fault_code == 3'd6 && pg_kill));

   p_enable_clear_r6: assert property (@(posedge clk) disable iff (!por_n)
      (!en && fault_code != 3'd6 && !sov_flag) |=> (!pg_kill || fault_code == 3'd6));

   p_first_fault_r11: assert property (@(posedge clk) disable iff (!por_n)
      (fault_code != 3'd0 && en) |=> $stable(fault_code));

   p_switch_excl_r10: assert property (@(posedge clk) disable iff (!por_n)
      $rose(lowside_on) |-> !all_off);
endmodule

bind fault_supervisor fsup_checker u_fsup_chk (
   .clk       (clk),
   .por_n     (por_n),
   .en        (en),
   .foc_flag  (foc_flag),
   .sov_flag  (sov_flag),
   .rel_flag  (rel_flag),
   .pg_kill   (pg_kill),
   .all_off   (all_off),
   .lowside_on(lowside_on),
   .fault_code(fault_code)
);

// File: tb/tb_fault_supervisor.sv
`timescale 1ns/1ps
module tb_fault_supervisor;
   localparam int OC_N   = 120;
   localparam int SLOW_N = 1000;

   logic clk = 1'b0;
   logic por_n, en, oc, foc, imb, uv, ov, sov, rel;
   logic pg_kill, all_off, lowside_on;
   logic [2:0] code;

   always #10 clk = ~clk;

   fault_supervisor #(.OC_CYC(OC_N), .SLOW_CYC(SLOW_N)) dut (
      .clk(clk), .por_n(por_n), .en(en),
      .oc_flag(oc), .foc_flag(foc), .imb_flag(imb), .uv_flag(uv),
      .ov_flag(ov), .sov_flag(sov), .rel_flag(rel),
      .pg_kill(pg_kill), .all_off(all_off), .lowside_on(lowside_on),
      .fault_code(code)
   );

   typedef struct {
      string      req;
      logic       pg;
      logic       off;
      logic       ls;
      logic [2:0] cd;
   } exp_t;

   exp_t exp_q[$];
   event chk_ev;
   int   checks = 0;
   int   failures = 0;
   bit   done = 0;

   // monitor: pops expected items and compares against the outputs
   initial begin
      forever begin
         @(chk_ev);
         while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (pg_kill !== e.pg || all_off !== e.off ||
                lowside_on !== e.ls || code !== e.cd) begin
               failures++;
               $display("FAIL %s: got pg=%b off=%b ls=%b code=%0d, expected pg=%b off=%b ls=%b code=%0d",
                        e.req, pg_kill, all_off, lowside_on, code,
                        e.pg, e.off, e.ls, e.cd);
            end
         end
      end
   end

   task automatic expect_out(input string req, input logic pg, input logic off,
                             input logic ls, input logic [2:0] cd);
      exp_t e;
      e.req = req; e.pg = pg; e.off = off; e.ls = ls; e.cd = cd;
      exp_q.push_back(e);
      ->chk_ev;
      #1;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_enable();
      oc = 0; foc = 0; imb = 0; uv = 0; ov = 0;
      en = 0;
      step(1);
      en = 1;
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      por_n = 0; en = 0; oc = 0; foc = 0; imb = 0; uv = 0; ov = 0; sov = 0; rel = 0;
      step(3);
      expect_out("R1 reset held", 0, 0, 0, 3'd0);
      por_n = 1;
      step(1);
      expect_out("R1 after reset", 0, 0, 0, 3'd0);
      en = 1;
      step(1);

      // R2: overcurrent persistence
      oc = 1;
      step(OC_N - 1);
      expect_out("R2 oc one edge short", 0, 0, 0, 3'd0);
      step(1);
      expect_out("R2 oc latched", 1, 1, 0, 3'd4);

      // R6: enable low clears the ordinary domain
      oc = 0; en = 0;
      step(1);
      expect_out("R6 enable clear", 0, 0, 0, 3'd0);
      foc = 1;
      step(5);
      expect_out("R6 ignored while disabled", 0, 0, 0, 3'd0);
      foc = 0; en = 1;
      step(1);

      // R3: interrupted overcurrent restarts its count
      oc = 1; step(100);
      oc = 0; step(1);
      oc = 1; step(OC_N - 1);
      expect_out("R3 restart count", 0, 0, 0, 3'd0);
      step(1);
      expect_out("R3 latch after restart", 1, 1, 0, 3'd4);
      clear_enable();

      // R4: fast overcurrent in one edge
      foc = 1; step(1);
      expect_out("R4 fast oc", 1, 1, 0, 3'd5);
      clear_enable();

      // R5: slow qualifiers
      imb = 1; step(SLOW_N - 1);
      expect_out("R5 imbalance short", 0, 0, 0, 3'd0);
      step(1);
      expect_out("R5 imbalance", 1, 1, 0, 3'd3);
      clear_enable();
      uv = 1; step(SLOW_N);
      expect_out("R5 undervoltage", 1, 1, 0, 3'd2);
      clear_enable();
      ov = 1; step(SLOW_N - 1);
      expect_out("R5 overvoltage short", 0, 0, 0, 3'd0);
      step(1);
      expect_out("R5 overvoltage", 1, 1, 0, 3'd1);
      clear_enable();

      // R11: same-edge priority, then first fault kept
      uv = 1; ov = 1; step(SLOW_N);
      expect_out("R11 uv beats ov", 1, 1, 0, 3'd2);
      foc = 1; step(1);
      expect_out("R11 first fault kept", 1, 1, 0, 3'd2);
      clear_enable();

      // R7 / R8: crowbar loop
      sov = 1; step(1);
      expect_out("R7 severe ov", 1, 0, 1, 3'd6);
      sov = 0; step(3);
      expect_out("R8 lowside holds", 1, 0, 1, 3'd6);
      rel = 1; step(1);
      expect_out("R8 release", 1, 1, 0, 3'd6);
      rel = 0; sov = 1; step(1);
      expect_out("R8 repeat", 1, 0, 1, 3'd6);
      sov = 0; rel = 1; step(1);
      rel = 0;
      expect_out("R8 second release", 1, 1, 0, 3'd6);

      // R9: enable cannot clear the severe latch
      en = 0; step(2);
      expect_out("R9 ignores enable", 1, 1, 0, 3'd6);
      por_n = 0; step(1);
      expect_out("R9 por clears", 0, 0, 0, 3'd0);
      por_n = 1; step(1);
      en = 1;
      step(1);

      // R10: severe detector after ordinary fault
      foc = 1; step(1);
      foc = 0;
      expect_out("R10 ordinary first", 1, 1, 0, 3'd5);
      sov = 1; step(1);
      expect_out("R10 crowbar overrides", 1, 0, 1, 3'd5);
      sov = 0; en = 0; step(1);
      expect_out("R9 code moves to severe", 1, 0, 1, 3'd6);
      rel = 1; step(1);
      rel = 0;
      expect_out("R10 release after", 1, 1, 0, 3'd6);
      por_n = 0; step(1);
      expect_out("R1 por again", 0, 0, 0, 3'd0);

      done = 1;
      #1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule